// File: doc/BRIEF.md
# Debug Link Timeout Monitor

This block watches a single-wire debug line whose level has already been brought into the target clock domain. Every falling edge seen on the line restarts one interval counter. The counter serves two purposes. A low level that outlasts a fixed limit is classed as a host SYNC request rather than a data bit. A gap between falling edges that outlasts a longer limit silently aborts whatever command or data return was under way.

Abort and end-of-SYNC are both reported as a one-cycle soft-reset pulse. The surrounding debug logic uses this pulse to drop its partial state. It never touches memory or operating mode. While a SYNC request is pending, a level output stays high. When the host releases the line, a response-start pulse tells the transmitter it may begin its answer.

While a flash mass erase is pending, an input flag holds off the gap abort. A one-cycle frame-start strobe marks the first falling edge after reset or after any soft reset, so the bit decoder knows a fresh command begins there.

Top module: `dbg_link_tmon`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, all four outputs are 0 and the block waits for a first falling edge.
- R2: A falling edge (line sampled 1 then 0 on consecutive clock edges) taken while waiting raises `frame_start_o` for exactly one cycle, starting one cycle after the sampling edge. Later falling edges in the same frame leave it at 0.
- R3: If the line is sampled low at the falling-edge clock and at each of the next SYNC_LIMIT clocks (default 128, so 129 low samples), `sync_det_o` rises after the last of them. With SYNC_LIMIT low samples or fewer, it stays 0.
- R4: While `sync_det_o` is high and the line stays low, no time limit applies: `sync_det_o` stays 1 and `soft_rst_o` stays 0, however long that lasts.
- R5: While waiting on a SYNC pulse, the first clock that samples the line high gives one cycle with `soft_rst_o` = 1 and `sync_rsp_o` = 1, and `sync_det_o` returns to 0 in that same cycle.
- R6: Inside a frame, if none of the GAP_LIMIT clocks (default 512) that follow the clock which sampled a falling edge samples another falling edge, `soft_rst_o` pulses for one cycle after the last of them. A falling edge sampled at the last of those clocks prevents the pulse and restarts the interval.
- R7: A gap abort gives a single pulse. Any further idle time, however long, gives no more pulses until a new falling edge opens a frame.
- R8: While `erase_pend_i` is 1, the gap abort is held off for as long as the flag stays set. The interval counter saturates and does not wrap. If the gap has already run out when the flag drops, the pulse is issued after the first clock that samples the flag low.
- R9: After any soft reset, the next falling edge is treated as the start of a new frame. It raises `frame_start_o` and can grow into a new SYNC request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Synchronised debug line level, 1 = released |
| erase_pend_i | input | 1 | Mass erase pending, holds off the gap abort |
| soft_rst_o | output | 1 | One-cycle discard pulse for partial command or data |
| sync_det_o | output | 1 | High while a SYNC request waits for line release |
| sync_rsp_o | output | 1 | One-cycle pulse: SYNC response may start |
| frame_start_o | output | 1 | One-cycle pulse on the first edge of a new frame |

## Verification
The bench tests both counter limits exactly at the boundary. A low pulse one sample too short must stay a data bit, and a falling edge on the final allowed clock must avoid the abort. An off-by-one design would flag a SYNC too early or abort a legal frame. A line held low for thousands of cycles tests the unbounded SYNC wait: a design that let the gap timer run there would issue a spurious soft reset. An erase hold longer than the counter's natural wrap checks saturation. A wrapping counter would miss the deferred abort once the flag drops, and a line left idle after an abort exposes repeated pulses.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;

    // Default limits, in target clock cycles.
    localparam int unsigned SYNC_LIMIT_DEF = 128;
    localparam int unsigned GAP_LIMIT_DEF  = 512;

    // Link supervision states.
    typedef enum logic [1:0] {
        LS_IDLE  = 2'd0,   // no frame open, waiting for a falling edge
        LS_FRAME = 2'd1,   // frame open, interval timer supervising
        LS_SYNC  = 2'd2    // SYNC request seen, waiting for release
    } link_state_e;

    // Per-cycle line events derived from the synchronised level.
    typedef struct packed {
        logic level;
        logic fall;
        logic rise;
    } line_ev_t;

    // Registered outputs of the link control.
    typedef struct packed {
        logic soft_rst;
        logic sync_det;
        logic sync_rsp;
        logic frame_start;
    } link_out_t;

    // Counter width able to hold the value lim without wrapping.
    function automatic int unsigned cnt_bits(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

    // Output bundle with every flag cleared.
    function automatic link_out_t quiet_outputs();
        link_out_t o;
        o.soft_rst    = 1'b0;
        o.sync_det    = 1'b0;
        o.sync_rsp    = 1'b0;
        o.frame_start = 1'b0;
        return o;
    endfunction

endpackage

// File: rtl/dbg_line_edge.sv
module dbg_line_edge
    import dbg_link_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    output line_ev_t ev_o
);

    // Previous sample; the released line idles high.
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= line_i;
        end
    end

    always_comb begin
        ev_o.level = line_i;
        ev_o.fall  = prev_q & ~line_i;
        ev_o.rise  = ~prev_q & line_i;
    end

endmodule

// File: rtl/dbg_gap_timer.sv
module dbg_gap_timer #(
    parameter int unsigned LIMIT = 512,
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Holds the number of clocks since the one that sampled the last
    // falling edge (that clock itself gives 1), saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= CNT_ONE;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/dbg_link_fsm.sv
module dbg_link_fsm
    import dbg_link_pkg::*;
#(
    parameter int unsigned SYNC_LIMIT = 128,
    parameter int unsigned GAP_LIMIT  = 512,
    parameter int unsigned CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             erase_i,
    output link_out_t        out_o
);

    localparam logic [CNT_W-1:0] SYNC_CNT = CNT_W'(SYNC_LIMIT);
    localparam logic [CNT_W-1:0] GAP_CNT  = CNT_W'(GAP_LIMIT);

    link_state_e st_q, st_n;
    link_out_t   out_q, out_n;
    logic        sync_hit;
    logic        gap_hit;

    // Line has been low since the edge for SYNC_LIMIT further clocks.
    assign sync_hit = ~ev_i.level & (cnt_i == SYNC_CNT);
    // Interval exhausted (counter sits saturated at the limit).
    assign gap_hit  = (cnt_i == GAP_CNT);

    always_comb begin
        st_n  = st_q;
        out_n = quiet_outputs();
        unique case (st_q)
            LS_IDLE: begin
                if (ev_i.fall) begin
                    st_n              = LS_FRAME;
                    out_n.frame_start = 1'b1;
                end
            end
            LS_FRAME: begin
                if (ev_i.fall) begin
                    st_n = LS_FRAME;          // new bit, timer restarts
                end else if (sync_hit) begin
                    st_n = LS_SYNC;
                end else if (gap_hit && !erase_i) begin
                    st_n           = LS_IDLE;
                    out_n.soft_rst = 1'b1;
                end
            end
            LS_SYNC: begin
                // No time limit here: only the release leaves this state.
                if (ev_i.rise) begin
                    st_n           = LS_IDLE;
                    out_n.soft_rst = 1'b1;
                    out_n.sync_rsp = 1'b1;
                end
            end
            default: begin
                st_n = LS_IDLE;
            end
        endcase
        out_n.sync_det = (st_n == LS_SYNC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LS_IDLE;
            out_q <= quiet_outputs();
        end else begin
            st_q  <= st_n;
            out_q <= out_n;
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/dbg_link_tmon.sv
module dbg_link_tmon
    import dbg_link_pkg::*;
#(
    parameter int unsigned SYNC_LIMIT = SYNC_LIMIT_DEF,
    parameter int unsigned GAP_LIMIT  = GAP_LIMIT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic erase_pend_i,
    output logic soft_rst_o,
    output logic sync_det_o,
    output logic sync_rsp_o,
    output logic frame_start_o
);

    // SYNC_LIMIT is expected to be below GAP_LIMIT so a held-low line is
    // classed as SYNC before the gap abort can fire.
    localparam int unsigned CNT_W = cnt_bits(GAP_LIMIT);

    line_ev_t         ev;
    logic [CNT_W-1:0] cnt;
    link_out_t        lo;

    dbg_line_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .ev_o   (ev)
    );

    dbg_gap_timer #(
        .LIMIT (GAP_LIMIT),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (ev.fall),
        .cnt_o     (cnt)
    );

    dbg_link_fsm #(
        .SYNC_LIMIT (SYNC_LIMIT),
        .GAP_LIMIT  (GAP_LIMIT),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .cnt_i   (cnt),
        .erase_i (erase_pend_i),
        .out_o   (lo)
    );

    assign soft_rst_o    = lo.soft_rst;
    assign sync_det_o    = lo.sync_det;
    assign sync_rsp_o    = lo.sync_rsp;
    assign frame_start_o = lo.frame_start;

endmodule

// File: rtl/dbg_link_tmon_chk.sv
module dbg_link_tmon_chk (
    input logic clk,
    input logic rst,
    input logic line_i,
    input logic erase_pend_i,
    input logic soft_rst_o,
    input logic sync_det_o,
    input logic sync_rsp_o,
    input logic frame_start_o
);

    // R1: reset leaves every output quiet on the following cycle.
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !soft_rst_o && !sync_det_o && !sync_rsp_o && !frame_start_o);

    // R2: frame start is a single-cycle strobe.
    p_frame_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> !frame_start_o);

    // R4: a held-low line keeps the SYNC wait alive.
    p_sync_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (sync_det_o && !line_i) |=> sync_det_o);

    // R5: the response pulse always comes with a soft reset.
    p_rsp_with_reset_r5: assert property (@(posedge clk) disable iff (rst)
        sync_rsp_o |-> soft_rst_o);

    // R5: leaving the SYNC wait is always marked by the response pulse.
    p_sync_exit_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_det_o) |-> sync_rsp_o);

    // R7: soft reset never lasts two cycles.
    p_single_reset_r7: assert property (@(posedge clk) disable iff (rst)
        soft_rst_o |=> !soft_rst_o);

    // R8: a gap abort is never issued while erase was pending.
    p_erase_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (soft_rst_o && !sync_rsp_o) |-> !$past(erase_pend_i));

    // R2: frame start never coincides with a SYNC wait or a reset.
    p_frame_clean_r2: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> !sync_det_o && !soft_rst_o);

endmodule

bind dbg_link_tmon dbg_link_tmon_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .line_i        (line_i),
    .erase_pend_i  (erase_pend_i),
    .soft_rst_o    (soft_rst_o),
    .sync_det_o    (sync_det_o),
    .sync_rsp_o    (sync_rsp_o),
    .frame_start_o (frame_start_o)
);

// File: tb/dbg_link_tmon_tb_top.sv
`timescale 1ns/1ps
module dbg_link_tmon_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_i = 1'b1;
    logic erase_pend_i = 1'b0;
    logic soft_rst_o, sync_det_o, sync_rsp_o, frame_start_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dbg_link_tmon dut_i (
        .clk           (clk),
        .rst           (rst),
        .line_i        (line_i),
        .erase_pend_i  (erase_pend_i),
        .soft_rst_o    (soft_rst_o),
        .sync_det_o    (sync_det_o),
        .sync_rsp_o    (sync_rsp_o),
        .frame_start_o (frame_start_o)
    );

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One sample: drive at negedge, observe just after the next posedge.
    task automatic tick(input logic lvl);
        @(negedge clk);
        line_i = lvl;
        @(posedge clk);
        #1;
    endtask

    // n samples at one level; count reset pulses and SYNC-high cycles.
    task automatic run(input logic lvl, input int n,
                       output int rpulses, output int dethi);
        rpulses = 0;
        dethi   = 0;
        for (int i = 0; i < n; i++) begin
            tick(lvl);
            if (soft_rst_o) rpulses++;
            if (sync_det_o) dethi++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        line_i = 1'b1;
        erase_pend_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        check(soft_rst_o,    0, "R1 soft_rst after reset");
        check(sync_det_o,    0, "R1 sync_det after reset");
        check(sync_rsp_o,    0, "R1 sync_rsp after reset");
        check(frame_start_o, 0, "R1 frame_start after reset");
    endtask

    task automatic t_frame_start();
        do_reset();
        tick(1'b0);
        check(frame_start_o, 1, "R2 strobe on first fall");
        tick(1'b1);
        check(frame_start_o, 0, "R2 strobe lasts one cycle");
        tick(1'b0);
        check(frame_start_o, 0, "R2 no strobe on later fall");
        tick(1'b1);
        check(soft_rst_o, 0, "R2 no reset inside frame");
    endtask

    task automatic t_gap();
        int rp, dh;
        do_reset();
        tick(1'b0);
        run(1'b1, 511, rp, dh);
        check(rp, 0, "R6 no pulse before limit");
        tick(1'b1);
        check(soft_rst_o, 1, "R6 pulse after 512 quiet clocks");
        tick(1'b1);
        check(soft_rst_o, 0, "R7 pulse is single");
        run(1'b1, 1500, rp, dh);
        check(rp, 0, "R7 no repeat pulses while idle");
        tick(1'b0);
        check(frame_start_o, 1, "R9 new frame after abort");
    endtask

    task automatic t_gap_edge();
        int rp, dh;
        do_reset();
        tick(1'b0);
        run(1'b1, 511, rp, dh);
        tick(1'b0);
        check(soft_rst_o + rp, 0, "R6 fall on last clock avoids abort");
        check(frame_start_o, 0, "R2 no strobe inside same frame");
        run(1'b1, 511, rp, dh);
        check(rp, 0, "R6 interval restarted by fall");
        tick(1'b1);
        check(soft_rst_o, 1, "R6 abort after restarted interval");
    endtask

    task automatic t_sync_short();
        int rp, dh;
        do_reset();
        run(1'b0, 128, rp, dh);
        check(dh, 0, "R3 128 low samples is no SYNC");
        tick(1'b1);
        check(sync_det_o, 0, "R3 short pulse stays a bit");
        check(soft_rst_o, 0, "R3 short pulse gives no reset");
    endtask

    task automatic t_sync();
        int rp, dh;
        do_reset();
        run(1'b0, 128, rp, dh);
        check(dh, 0, "R3 not yet SYNC at 128");
        tick(1'b0);
        check(sync_det_o, 1, "R3 SYNC after 129 low samples");
        run(1'b0, 3000, rp, dh);
        check(rp, 0, "R4 no timeout in SYNC wait");
        check(dh, 3000, "R4 SYNC held while low");
        tick(1'b1);
        check(soft_rst_o, 1, "R5 reset on release");
        check(sync_rsp_o, 1, "R5 response start on release");
        check(sync_det_o, 0, "R5 SYNC clears on release");
        tick(1'b1);
        check(soft_rst_o + sync_rsp_o, 0, "R5 release pulses last one cycle");
        tick(1'b0);
        check(frame_start_o, 1, "R9 new frame after SYNC");
        run(1'b0, 128, rp, dh);
        check(sync_det_o, 1, "R9 second SYNC detected");
    endtask

    task automatic t_erase();
        int rp, dh;
        do_reset();
        erase_pend_i = 1'b1;
        tick(1'b0);
        run(1'b1, 1500, rp, dh);
        check(rp, 0, "R8 abort held off during erase");
        erase_pend_i = 1'b0;
        tick(1'b1);
        check(soft_rst_o, 1, "R8 deferred abort after erase");
        tick(1'b1);
        check(soft_rst_o, 0, "R8 deferred abort single");
    endtask

    initial begin
        t_reset();
        t_frame_start();
        t_gap();
        t_gap_edge();
        t_sync_short();
        t_sync();
        t_erase();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule